// File: doc/BRIEF.md
# Card Socket Supply Switch Controller

This block turns the supply settings requested for two card sockets into the control lines of an external power switch. Each socket asks for any mix of four things: a 5 V supply, a 3.3 V supply, VPP tied to VCC, and VPP at programming voltage. Before any request reaches a pin, it is cleaned. A socket that asks for both VCC levels gets neither and raises its error flag. A socket that asks for both VPP sources gets neither VPP output and raises no flag.

A mode input picks one of two ways to drive the switch. In parallel mode, registered active-low VCC selects and active-high VPP lines go straight to the switch. In serial mode, three of those pins are reused as a shift clock, a data line and a latch line. The shift clock is a slow reference clock, synchronised into the system clock domain. A 16-bit frame carries both sockets, and a latch pulse follows it. A new frame is sent only when the cleaned settings differ from the frame last sent. The first frame after reset, and the first after entering serial mode, switches every supply off.

Top module: `sock_pwr_ctl`

## Requirements
- R1: While reset is asserted, and until the first clock after its synchronised release, `a5n_sclk`, `b3n_sdata`, `b5n_slatch` and `a_vcc3_n` are high, all four VPP outputs are low, and both error flags are low.
- R2: Request bit encoding is: bit0 asks for 5 V, bit1 for 3.3 V, bit2 for VPP from VCC, and bit3 for VPP programming voltage. In parallel mode, one clock after a request is applied, the outputs follow the cleaned request: `a5n_sclk` = not A 5 V, `a_vcc3_n` = not A 3.3 V, `b5n_slatch` = not B 5 V, `b3n_sdata` = not B 3.3 V, and each VPP output is active high.
- R3: A request with bit0 and bit1 both set drives both VCC selects of that socket off and sets that socket's error flag one clock later, in either mode. The flag clears once the request no longer conflicts. The two active-low VCC selects of a socket are never low together.
- R4: A request with bit2 and bit3 both set drives both VPP outputs of that socket low and leaves the error flag unchanged by that pair.
- R5: In serial mode, `a_vcc3_n` is held high and all VPP outputs are held low.
- R6: In serial mode, `a5n_sclk` carries the synchronised reference clock and `b3n_sdata` changes only on its falling edge. A frame is 16 bits, most significant first, socket A byte then socket B byte. Each byte is {4'b0000, bit3, bit2, bit1, bit0} of the cleaned request.
- R7: `b5n_slatch` rises on the falling shift-clock edge after the last bit, stays high for exactly one reference period, and data is low while it is high.
- R8: The first frame after reset, and the first after switching from parallel to serial mode, carries all zeros whatever the request.
- R9: A frame is started only when the cleaned request differs from the contents of the last frame sent. With unchanged requests, no further latch pulses occur.
- R10: A request change during a frame does not alter that frame. The new settings go out, complete, in the frame that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Slow reference clock (10 to 100 kHz) for the serial link |
| serial_mode | input | 1 | 1 selects the serial interface, 0 the parallel selects |
| req_a | input | 4 | Socket A supply request |
| req_b | input | 4 | Socket B supply request |
| a5n_sclk | output | 1 | Parallel: A 5 V select, active low. Serial: shift clock |
| b3n_sdata | output | 1 | Parallel: B 3.3 V select, active low. Serial: data |
| b5n_slatch | output | 1 | Parallel: B 5 V select, active low. Serial: latch |
| a_vcc3_n | output | 1 | A 3.3 V select, active low (parallel only) |
| a_vpp_vcc | output | 1 | A VPP from VCC, active high |
| a_vpp_pgm | output | 1 | A VPP programming voltage, active high |
| b_vpp_vcc | output | 1 | B VPP from VCC, active high |
| b_vpp_pgm | output | 1 | B VPP programming voltage, active high |
| err_a | output | 1 | Socket A requested both VCC levels |
| err_b | output | 1 | Socket B requested both VCC levels |

## Verification
The hardest case to reach from the ports is a request that changes while a frame is partly shifted out. The stimulus makes one change while the link is idle. It waits about six reference periods, so the first frame is known to be mid-shift, then applies a second change. The bench then expects two complete frames in order, each with its own contents, and no third. A long quiet window after every sequence, with nothing pending, shows that no spurious frame is sent. Returning from parallel mode with a non-zero request shows the all-off frame appearing first.

// File: rtl/spwr_pkg.sv
package spwr_pkg;
  localparam int REQ_W = 4;

  typedef struct packed {
    logic vpp_pgm;
    logic vpp_vcc;
    logic v3;
    logic v5;
  } sock_req_t;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_SHIFT = 2'd1,
    TX_LATCH = 2'd2
  } tx_state_t;
endpackage

// File: rtl/spwr_clean.sv
module spwr_clean
  import spwr_pkg::*;
(
  input  sock_req_t req,
  output sock_req_t clean,
  output logic      vcc_bad
);
  logic vpp_bad;

  always_comb begin
    vcc_bad       = req.v5 & req.v3;
    vpp_bad       = req.vpp_vcc & req.vpp_pgm;
    clean.v5      = req.v5 & ~vcc_bad;
    clean.v3      = req.v3 & ~vcc_bad;
    clean.vpp_vcc = req.vpp_vcc & ~vpp_bad;
    clean.vpp_pgm = req.vpp_pgm & ~vpp_bad;
  end
endmodule

// File: rtl/spwr_ref_sync.sv
module spwr_ref_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic level,
  output logic fall_tick
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], ref_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign level     = sh_q[STAGES-1];
  assign fall_tick = sh_q[STAGES-1] & ~sh_q[STAGES-2];
endmodule

// File: rtl/spwr_serial_tx.sv
module spwr_serial_tx
  import spwr_pkg::*;
#(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               tick,
  input  logic [FRAME_W-1:0] frame_in,
  output logic               data,
  output logic               latch
);
  localparam int CNT_W = $clog2(FRAME_W);

  tx_state_t          st_q, st_d;
  logic [FRAME_W-1:0] sh_q, sh_d, sent_q, sent_d, load;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               init_q, init_d, data_d, latch_d, pending;

  always_comb begin
    st_d    = st_q;
    sh_d    = sh_q;
    sent_d  = sent_q;
    cnt_d   = cnt_q;
    init_d  = init_q;
    data_d  = data;
    latch_d = latch;
    pending = init_q || (frame_in != sent_q);
    load    = init_q ? '0 : frame_in;
    if (!enable) begin
      st_d    = TX_IDLE;
      sent_d  = '0;
      init_d  = 1'b1;
      data_d  = 1'b0;
      latch_d = 1'b0;
    end else if (tick) begin
      unique case (st_q)
        TX_IDLE: if (pending) begin
          sh_d   = load;
          sent_d = load;
          data_d = load[FRAME_W-1];
          cnt_d  = CNT_W'(FRAME_W-1);
          init_d = 1'b0;
          st_d   = TX_SHIFT;
        end
        TX_SHIFT: if (cnt_q == '0) begin
          data_d  = 1'b0;
          latch_d = 1'b1;
          st_d    = TX_LATCH;
        end else begin
          sh_d   = sh_q << 1;
          data_d = sh_q[FRAME_W-2];
          cnt_d  = cnt_q - 1'b1;
        end
        default: begin
          latch_d = 1'b0;
          st_d    = TX_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      sh_q   <= '0;
      sent_q <= '0;
      cnt_q  <= '0;
      init_q <= 1'b1;
      data   <= 1'b0;
      latch  <= 1'b0;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      sent_q <= sent_d;
      cnt_q  <= cnt_d;
      init_q <= init_d;
      data   <= data_d;
      latch  <= latch_d;
    end
  end
endmodule

// File: rtl/sock_pwr_ctl.sv
module sock_pwr_ctl
  import spwr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_clk,
  input  logic       serial_mode,
  input  logic [3:0] req_a,
  input  logic [3:0] req_b,
  output logic       a5n_sclk,
  output logic       b3n_sdata,
  output logic       b5n_slatch,
  output logic       a_vcc3_n,
  output logic       a_vpp_vcc,
  output logic       a_vpp_pgm,
  output logic       b_vpp_vcc,
  output logic       b_vpp_pgm,
  output logic       err_a,
  output logic       err_b
);
  localparam int NSOCK   = 2;
  localparam int FRAME_W = NSOCK * BYTE_W;
  localparam int PAD_W   = BYTE_W - REQ_W;

  logic [1:0] rst_pipe;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i = rst_pipe[1];

  sock_req_t [NSOCK-1:0] req_arr, clean_arr, par_q, par_d;
  logic      [NSOCK-1:0] vcc_bad, err_q, err_d;
  logic      [FRAME_W-1:0] frame;
  logic                  mode_q, sclk_lvl, tick, tx_data, tx_latch;

  assign req_arr[0] = req_a;
  assign req_arr[1] = req_b;

  for (genvar s = 0; s < NSOCK; s++) begin : g_sock
    spwr_clean u_clean (
      .req     (req_arr[s]),
      .clean   (clean_arr[s]),
      .vcc_bad (vcc_bad[s])
    );
    assign frame[(NSOCK-1-s)*BYTE_W +: BYTE_W] = {{PAD_W{1'b0}}, clean_arr[s]};
  end

  always_comb begin
    par_d = clean_arr;
    err_d = vcc_bad;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      mode_q <= 1'b0;
      par_q  <= '0;
      err_q  <= '0;
    end else begin
      mode_q <= serial_mode;
      par_q  <= par_d;
      err_q  <= err_d;
    end
  end

  spwr_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_i),
    .ref_in    (ref_clk),
    .level     (sclk_lvl),
    .fall_tick (tick)
  );

  spwr_serial_tx #(.FRAME_W(FRAME_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_i),
    .enable   (mode_q),
    .tick     (tick),
    .frame_in (frame),
    .data     (tx_data),
    .latch    (tx_latch)
  );

  assign a5n_sclk   = mode_q ? sclk_lvl : ~par_q[0].v5;
  assign b3n_sdata  = mode_q ? tx_data  : ~par_q[1].v3;
  assign b5n_slatch = mode_q ? tx_latch : ~par_q[1].v5;
  assign a_vcc3_n   = mode_q | ~par_q[0].v3;
  assign a_vpp_vcc  = ~mode_q & par_q[0].vpp_vcc;
  assign a_vpp_pgm  = ~mode_q & par_q[0].vpp_pgm;
  assign b_vpp_vcc  = ~mode_q & par_q[1].vpp_vcc;
  assign b_vpp_pgm  = ~mode_q & par_q[1].vpp_pgm;
  assign err_a      = err_q[0];
  assign err_b      = err_q[1];
endmodule

// File: rtl/sock_pwr_ctl_chk.sv
module sock_pwr_ctl_chk (
  input logic clk,
  input logic rst_i,
  input logic mode_q,
  input logic a5n_sclk,
  input logic b3n_sdata,
  input logic b5n_slatch,
  input logic a_vcc3_n,
  input logic a_vpp_vcc,
  input logic a_vpp_pgm,
  input logic b_vpp_vcc,
  input logic b_vpp_pgm,
  input logic err_a,
  input logic err_b
);
  AST_A_VCC_EXCL: assert property (@(posedge clk) disable iff (!rst_i)
    !mode_q |-> (a5n_sclk || a_vcc3_n)); // R3
  AST_B_VCC_EXCL: assert property (@(posedge clk) disable iff (!rst_i)
    !mode_q |-> (b5n_slatch || b3n_sdata)); // R3
  AST_ERR_SELECTS_OFF: assert property (@(posedge clk) disable iff (!rst_i)
    (!mode_q && err_a) |-> (a5n_sclk && a_vcc3_n)); // R3
  AST_VPP_EXCL: assert property (@(posedge clk) disable iff (!rst_i)
    !(a_vpp_vcc && a_vpp_pgm) && !(b_vpp_vcc && b_vpp_pgm)); // R4
  AST_SERIAL_PINS_OFF: assert property (@(posedge clk) disable iff (!rst_i)
    mode_q |-> (a_vcc3_n && !a_vpp_vcc && !a_vpp_pgm && !b_vpp_vcc && !b_vpp_pgm)); // R5
  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_i)
    (mode_q && $past(mode_q) && (b3n_sdata != $past(b3n_sdata))) |-> $fell(a5n_sclk)); // R6
  AST_LATCH_DATA_LOW: assert property (@(posedge clk) disable iff (!rst_i)
    (mode_q && b5n_slatch) |-> !b3n_sdata); // R7
endmodule

bind sock_pwr_ctl sock_pwr_ctl_chk u_chk (
  .clk        (clk),
  .rst_i      (rst_i),
  .mode_q     (mode_q),
  .a5n_sclk   (a5n_sclk),
  .b3n_sdata  (b3n_sdata),
  .b5n_slatch (b5n_slatch),
  .a_vcc3_n   (a_vcc3_n),
  .a_vpp_vcc  (a_vpp_vcc),
  .a_vpp_pgm  (a_vpp_pgm),
  .b_vpp_vcc  (b_vpp_vcc),
  .b_vpp_pgm  (b_vpp_pgm),
  .err_a      (err_a),
  .err_b      (err_b)
);

// File: tb/sim_sock_pwr_ctl.sv
`timescale 1ns/1ps
module sim_sock_pwr_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int REF_HALF   = 4;
  localparam int REF_PERIOD = 2 * REF_HALF;

  logic clk = 1'b0, rst_n = 1'b0, ref_clk = 1'b0, serial_mode = 1'b1;
  logic [3:0] req_a = 4'd1, req_b = 4'd6;
  logic a5n_sclk, b3n_sdata, b5n_slatch, a_vcc3_n;
  logic a_vpp_vcc, a_vpp_pgm, b_vpp_vcc, b_vpp_pgm, err_a, err_b;

  int n_checks = 0, n_fail = 0, cycles = 0;
  bit cmp_on = 0, rx_on = 1, done = 0;
  int rx_count = 0, lat_cnt = 0;
  logic [15:0] hist = '0;
  logic [15:0] exp_q[$];
  logic p_sclk = 1'b0, p_data = 1'b0, p_latch = 1'b0;

  sock_pwr_ctl u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    repeat (REF_HALF) @(negedge clk);
    ref_clk = ~ref_clk;
  end

  function automatic logic [3:0] san(input logic [3:0] r);
    logic [3:0] o;
    o = r;
    if (r[0] && r[1]) o[1:0] = 2'b00;
    if (r[2] && r[3]) o[3:2] = 2'b00;
    return o;
  endfunction

  function automatic logic [15:0] frm(input logic [3:0] ra, input logic [3:0] rb);
    return {4'b0000, san(ra), 4'b0000, san(rb)};
  endfunction

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-clock reference comparison and serial receiver
  always @(negedge clk) begin
    logic [3:0] sa, sb;
    cycles++;
    sa = san(req_a);
    sb = san(req_b);
    if (cmp_on) begin
      check(err_a == (req_a[0] & req_a[1]), "R3 err_a", err_a, req_a[0] & req_a[1]);
      check(err_b == (req_b[0] & req_b[1]), "R3 err_b", err_b, req_b[0] & req_b[1]);
      if (!serial_mode) begin
        check({a5n_sclk, a_vcc3_n, b5n_slatch, b3n_sdata} == {~sa[0], ~sa[1], ~sb[0], ~sb[1]},
              "R2/R3 parallel VCC selects",
              {a5n_sclk, a_vcc3_n, b5n_slatch, b3n_sdata}, {~sa[0], ~sa[1], ~sb[0], ~sb[1]});
        check({a_vpp_vcc, a_vpp_pgm, b_vpp_vcc, b_vpp_pgm} == {sa[2], sa[3], sb[2], sb[3]},
              "R2/R4 parallel VPP lines",
              {a_vpp_vcc, a_vpp_pgm, b_vpp_vcc, b_vpp_pgm}, {sa[2], sa[3], sb[2], sb[3]});
      end else begin
        check({a_vcc3_n, a_vpp_vcc, a_vpp_pgm, b_vpp_vcc, b_vpp_pgm} == 5'b10000,
              "R5 serial-mode dedicated pins",
              {a_vcc3_n, a_vpp_vcc, a_vpp_pgm, b_vpp_vcc, b_vpp_pgm}, 5'b10000);
      end
    end
    if (rx_on && serial_mode && cmp_on) begin
      if (b3n_sdata != p_data)
        check(p_sclk && !a5n_sclk, "R6 data changes on falling shift clock", a5n_sclk, 0);
      if (b5n_slatch && !p_latch) begin
        rx_count++;
        if (exp_q.size() == 0) begin
          check(0, "R9 unexpected frame", hist, 0);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check(hist == e, "R6/R8/R10 frame contents", hist, e);
        end
      end
      if (b5n_slatch) lat_cnt++;
      if (!b5n_slatch && p_latch) begin
        check(lat_cnt == REF_PERIOD, "R7 latch width", lat_cnt, REF_PERIOD);
        lat_cnt = 0;
      end
      if (a5n_sclk && !p_sclk) hist = {hist[14:0], b3n_sdata};
    end
    p_sclk  = a5n_sclk;
    p_data  = b3n_sdata;
    p_latch = b5n_slatch;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_frames(input int target);
    int t = 0;
    while (rx_count < target && t < 4000) begin
      @(negedge clk);
      t++;
    end
    check(rx_count >= target, "R6 frame arrival", rx_count, target);
    step(2 * REF_PERIOD);
  endtask

  task automatic set_req(input logic [3:0] a, input logic [3:0] b);
    req_a = a;
    req_b = b;
  endtask

  initial begin
    // R1: reset levels, serial requested but not yet active
    step(4);
    check({a5n_sclk, b3n_sdata, b5n_slatch, a_vcc3_n} == 4'hF, "R1 reset selects off",
          {a5n_sclk, b3n_sdata, b5n_slatch, a_vcc3_n}, 4'hF);
    check({a_vpp_vcc, a_vpp_pgm, b_vpp_vcc, b_vpp_pgm, err_a, err_b} == 6'b0,
          "R1 reset VPP and flags", {a_vpp_vcc, a_vpp_pgm, b_vpp_vcc, b_vpp_pgm, err_a, err_b}, 0);
    exp_q.push_back(16'h0000);          // R8 first frame all off
    exp_q.push_back(frm(4'd1, 4'd6));
    rst_n = 1'b1;
    step(6);
    cmp_on = 1;
    wait_frames(2);

    // R3 and R4 in serial: VCC conflict on A, VPP conflict on B
    set_req(4'b0011, 4'b1100);
    exp_q.push_back(frm(4'b0011, 4'b1100));
    wait_frames(3);

    // R10: change held during a frame in progress
    set_req(4'b0010, 4'b1001);
    exp_q.push_back(frm(4'b0010, 4'b1001));
    step(6 * REF_PERIOD);
    set_req(4'b0101, 4'b0010);
    exp_q.push_back(frm(4'b0101, 4'b0010));
    wait_frames(5);

    // R9: no change, no frame
    step(40 * REF_PERIOD);
    check(rx_count == 5, "R9 quiet link", rx_count, 5);
    check(exp_q.size() == 0, "R10 all expected frames seen", exp_q.size(), 0);

    // parallel mode patterns (R2, R3, R4)
    rx_on = 0;
    cmp_on = 0;
    serial_mode = 1'b0;
    step(3);
    cmp_on = 1;
    set_req(4'd1, 4'd2);       step(3);
    set_req(4'd2, 4'd1);       step(3);
    set_req(4'd3, 4'd0);       step(3);
    set_req(4'd12, 4'd5);      step(3);
    set_req(4'd0, 4'd15);      step(3);
    set_req(4'd4, 4'd8);       step(3);
    set_req(4'd8, 4'd4);       step(1);
    set_req(4'd3, 4'd3);       step(3);

    // back to serial: R8 all-off frame first
    set_req(4'b0101, 4'b1010);
    cmp_on = 0;
    serial_mode = 1'b1;
    step(4);
    cmp_on = 1;
    rx_on = 1;
    exp_q.push_back(16'h0000);
    exp_q.push_back(frm(4'b0101, 4'b1010));
    wait_frames(7);
    step(30 * REF_PERIOD);
    check(rx_count == 7 && exp_q.size() == 0, "R9 R8 frame count after re-entry", rx_count, 7);
    done = 1;
  end

  initial begin
    while (!done && cycles < 100000) @(negedge clk);
    if (!done) check(0, "watchdog", cycles, 100000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule